// File: doc/BRIEF.md
# Color Lookup Pixel Pipeline

This block is the pixel-side datapath of a video color lookup table. On every pixel clock it takes in a 24-bit pixel word, a 2-bit mode select and four video timing signals. From these it forms one 13-bit address for each of three 8-bit palette arrays (red, green, blue) and reads all three. It then presents the 24-bit color, together with the timing signals, a fixed four clocks later.

In index mode one 13-bit pixel index addresses all three arrays, so the palette holds 8192 colors. In direct mode each 8-bit channel of the pixel looks up its own array in one of three fixed upper banks. Each bank can therefore hold a separate per-channel gamma curve.

A single write port loads the arrays when an external FIFO drain requests it. A hold input freezes the color output while the arrays are borrowed for host access. Control bits can force each timing line. Lines 0 and 1 can be forced low and lines 2 and 3 can be forced high.

Top module: `clut_pixel_pipe`

## Requirements
- R1: With `mode` = 00, `pix_in[12:0]` addresses the red, green and blue arrays alike, and `pix_in[23:13]` has no effect on the output.
- R2: With `mode` nonzero, the red address is {bank, `pix_in[7:0]`}, the green address is {bank, `pix_in[15:8]`} and the blue address is {bank, `pix_in[23:16]`}, where bank is the 5-bit upper address.
- R3: The bank is 5'b11101 for `mode` 01, 5'b11110 for `mode` 10 and 5'b11111 for `mode` 11, with the MSB on the left.
- R4: `color_out[7:0]` is red, `[15:8]` is green and `[23:16]` is blue. A write stores `wr_data[7:0]` to red, `[15:8]` to green and `[23:16]` to blue, all at `wr_addr`.
- R5: An input sampled at rising edge k appears on `color_out` and `tim_out` after edge k+3, so there are four register stages. A new input is accepted every clock.
- R6: `tim_out[0]` = `tim_in[0]` & `tim_ctl[0]` and `tim_out[1]` = `tim_in[1]` & `tim_ctl[1]`. `tim_out[2]` = `tim_in[2]` | `tim_ctl[2]` and `tim_out[3]` = `tim_in[3]` | `tim_ctl[3]`. All four use values sampled together with the pixel.
- R7: While `hold` is high at an edge, `color_out` keeps its value, while `tim_out` continues to advance.
- R8: A write and a lookup of the same location at the same edge return the old contents; later lookups return the new contents.
- R9: Asynchronous active-low `rst_n` clears all pipeline registers, so `color_out` and `tim_out` read zero. The palette contents are not reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| pix_in | input | 24 | Pixel word |
| mode | input | 2 | 00 index mode, otherwise direct mode with bank select |
| tim_in | input | 4 | Video timing signals |
| tim_ctl | input | 4 | Force bits: [1:0] gate low, [3:2] force high |
| hold | input | 1 | Freeze the color output |
| wr_en | input | 1 | Palette write request |
| wr_addr | input | 13 | Palette write address |
| wr_data | input | 24 | Palette write data, blue:green:red |
| color_out | output | 24 | Looked-up color, blue:green:red |
| tim_out | output | 4 | Timing signals aligned with color_out |

## Verification
The checks on the timing lines assume that `tim_in` and `tim_ctl` are free of unknown values once reset is released. They compare the output against the inputs only after four clocks have passed since reset. The hold check assumes that `hold` is sampled cleanly at the clock edge. The stimulus satisfies these assumptions by driving every input, including `tim_ctl`, only on falling edges and from defined values at all times. It loads every palette location through the write port before any lookup is compared, so each expected color comes from a known array entry.

// File: rtl/clut_pixel_pipe.sv
module clut_pixel_pipe #(
  parameter int CH_W  = 8,
  parameter int BNK_W = 5
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [3*CH_W-1:0]     pix_in,
  input  logic [1:0]            mode,
  input  logic [3:0]            tim_in,
  input  logic [3:0]            tim_ctl,
  input  logic                  hold,
  input  logic                  wr_en,
  input  logic [CH_W+BNK_W-1:0] wr_addr,
  input  logic [3*CH_W-1:0]     wr_data,
  output logic [3*CH_W-1:0]     color_out,
  output logic [3:0]            tim_out
);
  localparam int AW    = CH_W + BNK_W;
  localparam int DEPTH = 1 << AW;
  localparam int PW    = 3 * CH_W;

  logic [PW-1:0] pix_q;
  logic [1:0]    mode_q;
  logic [3:0]    tim_q, tim_a, tim_r;
  logic [3:0]    tim_f;

  assign tim_f = {tim_in[3:2] | tim_ctl[3:2], tim_in[1:0] & tim_ctl[1:0]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pix_q   <= '0;
      mode_q  <= '0;
      tim_q   <= '0;
      tim_a   <= '0;
      tim_r   <= '0;
      tim_out <= '0;
    end else begin
      pix_q   <= pix_in;
      mode_q  <= mode;
      tim_q   <= tim_f;
      tim_a   <= tim_q;
      tim_r   <= tim_a;
      tim_out <= tim_r;
    end
  end

  for (genvar c = 0; c < 3; c++) begin : g_ch
    logic [CH_W-1:0] mem [DEPTH];
    logic [AW-1:0]   addr_d, addr_q;
    logic [CH_W-1:0] rd_q;

    assign addr_d = (mode_q == 2'b00) ? pix_q[AW-1:0]
                  : {{(BNK_W-2){1'b1}}, mode_q, pix_q[c*CH_W +: CH_W]};

    always_ff @(posedge clk) begin
      if (wr_en) mem[wr_addr] <= wr_data[c*CH_W +: CH_W];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        addr_q                     <= '0;
        rd_q                       <= '0;
        color_out[c*CH_W +: CH_W]  <= '0;
      end else begin
        addr_q <= addr_d;
        rd_q   <= mem[addr_q];
        if (!hold) color_out[c*CH_W +: CH_W] <= rd_q;
      end
    end
  end
endmodule

// File: rtl/clut_pixel_pipe_chk.sv
module clut_pixel_pipe_chk #(
  parameter int PW = 24
) (
  input logic          clk,
  input logic          rst_n,
  input logic [3:0]    tim_in,
  input logic [3:0]    tim_ctl,
  input logic          hold,
  input logic [PW-1:0] color_out,
  input logic [3:0]    tim_out
);
  logic [2:0] age;
  logic       warm;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          age <= '0;
    else if (age != 3'd7) age <= age + 3'd1;
  end
  assign warm = (age >= 3'd4);

  assert_tim_gate_R6: assert property (@(posedge clk) disable iff (!rst_n)
    warm |-> tim_out[1:0] == ($past(tim_in[1:0], 4) & $past(tim_ctl[1:0], 4)));

  assert_tim_force_R6: assert property (@(posedge clk) disable iff (!rst_n)
    warm |-> tim_out[3:2] == ($past(tim_in[3:2], 4) | $past(tim_ctl[3:2], 4)));

  assert_tim_latency_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (warm && $past(tim_ctl, 4) == 4'b0011) |-> tim_out == $past(tim_in, 4));

  assert_hold_freeze_R7: assert property (@(posedge clk) disable iff (!rst_n)
    hold |=> $stable(color_out));
endmodule

bind clut_pixel_pipe clut_pixel_pipe_chk #(.PW(3*CH_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .tim_in(tim_in), .tim_ctl(tim_ctl),
  .hold(hold), .color_out(color_out), .tim_out(tim_out)
);

// File: tb/clut_pixel_pipe_tb.sv
module clut_pixel_pipe_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [23:0] pix_in;
  logic [1:0]  mode;
  logic [3:0]  tim_in, tim_ctl;
  logic        hold, wr_en;
  logic [12:0] wr_addr;
  logic [23:0] wr_data;
  logic [23:0] color_out;
  logic [3:0]  tim_out;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  clut_pixel_pipe dut_i (
    .clk(clk), .rst_n(rst_n), .pix_in(pix_in), .mode(mode),
    .tim_in(tim_in), .tim_ctl(tim_ctl), .hold(hold), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .color_out(color_out), .tim_out(tim_out)
  );

  function automatic logic [7:0] f_red(logic [12:0] a);
    return a[7:0] + {a[12:8], 3'b101};
  endfunction
  function automatic logic [7:0] f_grn(logic [12:0] a);
    return ~a[7:0] ^ {3'b000, a[12:8]};
  endfunction
  function automatic logic [7:0] f_blu(logic [12:0] a);
    return {a[4:0], a[7:5]} + 8'(a[12:8] * 9);
  endfunction
  function automatic logic [23:0] entry(logic [12:0] a);
    return {f_blu(a), f_grn(a), f_red(a)};
  endfunction

  function automatic logic [23:0] exp_col(logic [1:0] m, logic [23:0] p);
    logic [12:0] ar, ag, ab;
    if (m == 2'b00) begin
      ar = p[12:0]; ag = p[12:0]; ab = p[12:0];
    end else begin
      ar = {3'b111, m, p[7:0]};
      ag = {3'b111, m, p[15:8]};
      ab = {3'b111, m, p[23:16]};
    end
    return {f_blu(ab), f_grn(ag), f_red(ar)};
  endfunction

  function automatic logic [3:0] exp_tim(logic [3:0] t, logic [3:0] c);
    return {t[3:2] | c[3:2], t[1:0] & c[1:0]};
  endfunction

  task automatic chk(input string tag, input logic [27:0] act, input logic [27:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  localparam int NV = 14;
  localparam logic [33:0] VEC [NV] = '{
    {2'b00, 24'h000123, 4'hF, 4'h3},
    {2'b00, 24'hFFE123, 4'hF, 4'h3},
    {2'b00, 24'h001FFF, 4'h5, 4'h3},
    {2'b00, 24'h000000, 4'hA, 4'h0},
    {2'b01, 24'h10A0F0, 4'h3, 4'h3},
    {2'b10, 24'h10A0F0, 4'hC, 4'hC},
    {2'b11, 24'h10A0F0, 4'h0, 4'h4},
    {2'b01, 24'hFF0000, 4'h9, 4'h8},
    {2'b10, 24'h00FF00, 4'h6, 4'h1},
    {2'b11, 24'h0000FF, 4'h7, 4'h2},
    {2'b00, 24'hABC800, 4'h1, 4'hF},
    {2'b11, 24'h7F8001, 4'hE, 4'h3},
    {2'b01, 24'h5A3C96, 4'h2, 4'h0},
    {2'b00, 24'h00155A, 4'hD, 4'h3}
  };

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [23:0] held;
    rst_n = 1'b0; pix_in = '0; mode = '0; tim_in = '0; tim_ctl = '0;
    hold = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0;
    #1;
    chk("R9 reset state", {tim_out, color_out}, 28'h0);
    repeat (2) @(negedge clk);
    rst_n = 1'b1;

    for (int a = 0; a < 8192; a++) begin
      @(negedge clk);
      wr_en = 1'b1; wr_addr = 13'(a); wr_data = entry(13'(a));
    end
    @(negedge clk);
    wr_en = 1'b0;
    repeat (5) @(negedge clk);

    // R1 R2 R3 R4 R5 R6: back-to-back stream, each output checked four edges later
    for (int i = 0; i < NV + 4; i++) begin
      @(negedge clk);
      if (i >= 4)
        chk($sformatf("R1/R2/R3/R4/R5/R6 vector %0d", i - 4), {tim_out, color_out},
            {exp_tim(VEC[i-4][7:4], VEC[i-4][3:0]), exp_col(VEC[i-4][33:32], VEC[i-4][31:8])});
      if (i < NV) begin
        mode = VEC[i][33:32]; pix_in = VEC[i][31:8];
        tim_in = VEC[i][7:4]; tim_ctl = VEC[i][3:0];
      end else begin
        mode = '0; pix_in = '0; tim_in = '0; tim_ctl = 4'h3;
      end
    end

    // R8: write and lookup of index 0ABC meet at the same edge
    @(negedge clk);
    mode = 2'b00; pix_in = 24'h000ABC; tim_in = 4'h0; tim_ctl = 4'h3;
    @(negedge clk);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 13'h0ABC; wr_data = 24'h5AA55A;
    @(negedge clk);
    wr_en = 1'b0;
    @(negedge clk);
    chk("R8 collision returns old", {4'h0, color_out}, {4'h0, entry(13'h0ABC)});
    @(negedge clk);
    chk("R8 later lookup returns new", {4'h0, color_out}, {4'h0, 24'h5AA55A});

    // R7: hold freezes color while timing flows
    pix_in = 24'h000321; tim_in = 4'h0; tim_ctl = 4'h3;
    repeat (5) @(negedge clk);
    held = color_out;
    chk("R7 pre-hold value", {4'h0, held}, {4'h0, entry(13'h0321)});
    hold = 1'b1; pix_in = 24'h001456; tim_in = 4'h3; tim_ctl = 4'h3;
    repeat (5) @(negedge clk);
    chk("R7 color frozen under hold", {4'h0, color_out}, {4'h0, held});
    chk("R7 timing advances under hold", {tim_out, 24'h0}, {4'h3, 24'h0});
    hold = 1'b0;
    @(negedge clk);
    chk("R7 release shows new lookup", {4'h0, color_out}, {4'h0, entry(13'h1456)});

    // R9: asynchronous reset mid-run, palette retained
    tim_ctl = 4'hC;
    repeat (5) @(negedge clk);
    #2;
    rst_n = 1'b0;
    #1;
    chk("R9 async clear", {tim_out, color_out}, 28'h0);
    @(negedge clk);
    rst_n = 1'b1; tim_ctl = 4'h3; tim_in = 4'h0; pix_in = 24'h000321;
    repeat (5) @(negedge clk);
    chk("R9 palette survives reset", {4'h0, color_out}, {4'h0, entry(13'h0321)});

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule